// File: doc/BRIEF.md
# Hot Path Profiling Message Builder

This block watches the stream of retired instructions from a processor core and condenses likely hot program paths into short digests. A digest holds the PC at which the path began, one taken/not-taken bit per conditional branch seen along the path, and a count of how many of those bits are valid. Capture begins on a backward taken branch or a call outside a trace, or when the core leaves a trace. Only one digest is built at a time, and trigger events that arrive while one is in progress are discarded.

A digest ends when the branch count reaches the limit set by a parameter, or earlier when the core starts retiring instructions from a trace. A finished digest is offered on a valid/ready output for exactly one cycle. If the consumer takes it, no further digest may leave until the consumer returns an acknowledge pulse. A digest that finishes while an acknowledge is still owed, or that the consumer does not take in its offer cycle, is discarded. In both cases the builder goes back to idle.

The controller has three states. In S_IDLE it waits for a trigger. In S_BUILD it collects branch bits. In S_EMIT it drives the output valid for one cycle. The transitions are:
- S_IDLE to S_BUILD on a trigger.
- S_BUILD to S_EMIT on completion when no acknowledge is owed.
- S_BUILD to S_IDLE on completion while an acknowledge is owed (the digest is dropped).
- S_EMIT to S_IDLE always, whether or not the digest was taken.

Top module: `hpm_builder`

## Requirements
- R1: An instruction retired with `ret_in_trace`=0, `ret_is_branch`=1, `ret_taken`=1 and `ret_target` < `ret_pc` (unsigned) starts a digest when the builder is idle. A forward taken branch, or any branch retired with `ret_in_trace`=1, does not start one.
- R2: When idle, a digest is also started by an instruction retired with `ret_in_trace`=0 and `ret_is_call`=1, or by any instruction retired with `ret_trace_exit`=1.
- R3: While a digest is being built, further trigger events do not restart it and do not change its start PC.
- R4: On a start, the digest PC is the `ret_pc` of the triggering instruction, and the bit vector and the count begin empty. The triggering instruction contributes no bit.
- R5: Each later retired branch (`ret_is_branch`=1, `ret_in_trace`=0) writes `ret_taken` into bit [count] of `msg_dirs`, so the first branch lands in bit 0, and the count goes up by one. Non-branch instructions add nothing. Bits at and above `msg_len` read as 0.
- R6: A digest completes on the branch that brings the count to BR_LIMIT, or earlier on any retired instruction with `ret_in_trace`=1. That instruction adds no bit, and the count may be 0. `msg_valid` is high during the single cycle that follows the completing retire.
- R7: After a digest is taken (`msg_valid` and `msg_ready` both high), any digest that completes before an `ack` pulse is dropped without raising `msg_valid`.
- R8: A digest not taken in its offer cycle is discarded. The builder returns to idle, and no acknowledge is owed for it.
- R9: When one retired instruction both completes a digest and is a trigger, only the completion takes effect, and no new digest starts from that instruction.
- R10: After reset, the builder is idle and `msg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | PC of the retiring instruction |
| ret_is_branch | input | 1 | Retiring instruction is a conditional branch |
| ret_taken | input | 1 | Branch was taken |
| ret_target | input | PC_W | Branch target address |
| ret_is_call | input | 1 | Retiring instruction is a jump-and-link |
| ret_in_trace | input | 1 | Instruction was fetched from a trace |
| ret_trace_exit | input | 1 | Instruction leaves a trace (early or regular exit) |
| msg_valid | output | 1 | Digest offered this cycle |
| msg_ready | input | 1 | Consumer accepts the offered digest |
| msg_pc | output | PC_W | Start PC of the digest |
| msg_dirs | output | BR_LIMIT | Branch directions, first branch in bit 0 |
| msg_len | output | LEN_W | Number of valid direction bits |
| ack | input | 1 | Consumer acknowledges the last accepted digest |

## Verification
The bench builds the block with PC_W=16 and BR_LIMIT=4. The small limit brings full-length completion within a few retires, so the case where the limit-reaching branch is itself a backward taken trigger is easy to reach. It also lets a zero-length digest, a short digest and a full digest sit side by side in one short run. Drops are exercised in both forms, once under an owed acknowledge and once under a refused offer. After each drop, later traffic is checked to confirm that no stray digest appears.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BUILD = 2'd1,
        S_EMIT  = 2'd2
    } hpm_state_e;

endpackage

// File: rtl/hpm_start_detect.sv
module hpm_start_detect #(
    parameter int PC_W = 32
) (
    input  logic            is_branch,
    input  logic            taken,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    input  logic            is_call,
    input  logic            in_trace,
    input  logic            trace_exit,
    output logic            start_evt
);

    logic back_branch;

    always_comb begin
        back_branch = is_branch && taken && (target < pc);
        start_evt   = trace_exit || (!in_trace && (is_call || back_branch));
    end

endmodule

// File: rtl/hpm_dir_shift.sv
module hpm_dir_shift #(
    parameter int BR_LIMIT = 8,
    parameter int LEN_W    = $clog2(BR_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift,
    input  logic                bit_in,
    output logic [BR_LIMIT-1:0] dirs_nx,
    output logic [LEN_W-1:0]    len_nx,
    output logic                at_limit
);

    localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(BR_LIMIT - 1);

    logic [BR_LIMIT-1:0] dirs_q;
    logic [LEN_W-1:0]    len_q;

    always_comb begin
        dirs_nx = dirs_q;
        len_nx  = len_q;
        if (clear) begin
            dirs_nx = '0;
            len_nx  = '0;
        end else if (shift) begin
            for (int i = 0; i < BR_LIMIT; i++) begin
                if (LEN_W'(i) == len_q) begin
                    dirs_nx[i] = bit_in;
                end
            end
            len_nx = len_q + 1'b1;
        end
        at_limit = (len_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirs_q <= '0;
            len_q  <= '0;
        end else begin
            dirs_q <= dirs_nx;
            len_q  <= len_nx;
        end
    end

    // R5
    len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(BR_LIMIT));

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (len_q == '0 && dirs_q == '0));

endmodule

// File: rtl/hpm_ack_tracker.sv
module hpm_ack_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic ack,
    output logic pending,
    output logic pending_eff
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    always_comb pending_eff = pending && !ack;

    // R7
    accept_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pending);

endmodule

// File: rtl/hpm_builder.sv
module hpm_builder
    import hpm_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int BR_LIMIT = 8,
    parameter int LEN_W    = $clog2(BR_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_valid,
    input  logic [PC_W-1:0]     ret_pc,
    input  logic                ret_is_branch,
    input  logic                ret_taken,
    input  logic [PC_W-1:0]     ret_target,
    input  logic                ret_is_call,
    input  logic                ret_in_trace,
    input  logic                ret_trace_exit,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [PC_W-1:0]     msg_pc,
    output logic [BR_LIMIT-1:0] msg_dirs,
    output logic [LEN_W-1:0]    msg_len,
    input  logic                ack
);

    hpm_state_e state_q, state_d;

    logic                start_evt;
    logic                load, shift, complete;
    logic                at_limit;
    logic                pending, pending_eff;
    logic                accept;
    logic [BR_LIMIT-1:0] dirs_nx;
    logic [LEN_W-1:0]    len_nx;
    logic [PC_W-1:0]     start_pc_q;
    logic [PC_W-1:0]     out_pc_q;
    logic [BR_LIMIT-1:0] out_dirs_q;
    logic [LEN_W-1:0]    out_len_q;

    hpm_start_detect #(.PC_W(PC_W)) u_start (
        .is_branch  (ret_is_branch),
        .taken      (ret_taken),
        .pc         (ret_pc),
        .target     (ret_target),
        .is_call    (ret_is_call),
        .in_trace   (ret_in_trace),
        .trace_exit (ret_trace_exit),
        .start_evt  (start_evt)
    );

    hpm_dir_shift #(.BR_LIMIT(BR_LIMIT), .LEN_W(LEN_W)) u_dirs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .shift    (shift),
        .bit_in   (ret_taken),
        .dirs_nx  (dirs_nx),
        .len_nx   (len_nx),
        .at_limit (at_limit)
    );

    hpm_ack_tracker u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .ack         (ack),
        .pending     (pending),
        .pending_eff (pending_eff)
    );

    // next-state and control decode
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        shift    = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (ret_valid && start_evt) begin
                    load    = 1'b1;
                    state_d = S_BUILD;
                end
            end
            S_BUILD: begin
                if (ret_valid) begin
                    if (ret_in_trace) begin
                        complete = 1'b1;
                    end else if (ret_is_branch) begin
                        shift    = 1'b1;
                        complete = at_limit;
                    end
                end
                if (complete) begin
                    state_d = pending_eff ? S_IDLE : S_EMIT;
                end
            end
            S_EMIT: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pc_q <= '0;
            out_pc_q   <= '0;
            out_dirs_q <= '0;
            out_len_q  <= '0;
        end else begin
            if (load) begin
                start_pc_q <= ret_pc;
            end
            if (complete) begin
                out_pc_q   <= start_pc_q;
                out_dirs_q <= dirs_nx;
                out_len_q  <= len_nx;
            end
        end
    end

    // outputs
    always_comb begin
        msg_valid = (state_q == S_EMIT);
        msg_pc    = out_pc_q;
        msg_dirs  = out_dirs_q;
        msg_len   = out_len_q;
        accept    = msg_valid && msg_ready;
    end

    // R6
    single_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    // R7
    no_emit_while_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |-> !msg_valid);

    // R5
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_dirs >> msg_len) == '0));

    // R3
    start_pc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUILD && $past(state_q) == S_BUILD) |-> $stable(start_pc_q));

    // R8
    emit_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT) |=> (state_q == S_IDLE));

endmodule

// File: tb/tb_hpm_builder.sv
module tb_hpm_builder;

    localparam int PW  = 16;
    localparam int LIM = 4;
    localparam int LW  = $clog2(LIM + 1);

    typedef struct packed {
        logic [PW-1:0]  pc;
        logic [LIM-1:0] dirs;
        logic [LW-1:0]  len;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ret_valid = 1'b0;
    logic [PW-1:0]  ret_pc = '0;
    logic           ret_is_branch = 1'b0;
    logic           ret_taken = 1'b0;
    logic [PW-1:0]  ret_target = '0;
    logic           ret_is_call = 1'b0;
    logic           ret_in_trace = 1'b0;
    logic           ret_trace_exit = 1'b0;
    logic           msg_ready = 1'b1;
    logic           ack = 1'b0;
    logic           msg_valid;
    logic [PW-1:0]  msg_pc;
    logic [LIM-1:0] msg_dirs;
    logic [LW-1:0]  msg_len;

    exp_t  expq[$];
    string tagq[$];
    int    nchk = 0;
    int    nfail = 0;
    int    offers = 0;
    int    accepts = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    hpm_builder #(.PC_W(PW), .BR_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_is_branch(ret_is_branch), .ret_taken(ret_taken), .ret_target(ret_target),
        .ret_is_call(ret_is_call), .ret_in_trace(ret_in_trace),
        .ret_trace_exit(ret_trace_exit), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_pc(msg_pc), .msg_dirs(msg_dirs), .msg_len(msg_len), .ack(ack)
    );

    task automatic chk(input string rq, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic expect_msg(input string rq, input logic [PW-1:0] pc,
                              input logic [LIM-1:0] dirs, input logic [LW-1:0] len);
        exp_t e;
        e.pc = pc; e.dirs = dirs; e.len = len;
        expq.push_back(e);
        tagq.push_back(rq);
    endtask

    task automatic retire(input logic [PW-1:0] pc, input logic br, input logic tk,
                          input logic [PW-1:0] tgt, input logic call,
                          input logic intr, input logic tex);
        @(posedge clk); #2;
        ret_valid = 1'b1; ret_pc = pc; ret_is_branch = br; ret_taken = tk;
        ret_target = tgt; ret_is_call = call; ret_in_trace = intr;
        ret_trace_exit = tex; ack = 1'b0;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            ret_valid = 1'b0; ret_is_branch = 1'b0; ret_taken = 1'b0;
            ret_is_call = 1'b0; ret_in_trace = 1'b0; ret_trace_exit = 1'b0;
            ack = 1'b0;
        end
    endtask

    task automatic send_ack();
        @(posedge clk); #2;
        ret_valid = 1'b0; ack = 1'b1;
        @(posedge clk); #2;
        ack = 1'b0;
    endtask

    task automatic fwd_br(input logic [PW-1:0] pc, input logic tk);
        retire(pc, 1'b1, tk, pc + 16'h0040, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic call_at(input logic [PW-1:0] pc);
        retire(pc, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic enter_trace(input logic [PW-1:0] pc);
        retire(pc, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            offers++;
            if (msg_ready) begin
                accepts++;
                if (expq.size() == 0) begin
                    chk("R7/R9 unexpected digest", 1'b0, {msg_pc, msg_dirs, msg_len}, 64'h0);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(t, {msg_pc, msg_dirs, msg_len} == e,
                        {msg_pc, msg_dirs, msg_len}, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int o0, a0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R10: idle with nothing offered after reset
        chk("R10 reset valid", msg_valid == 1'b0, msg_valid, 0);

        // R1 R4 R5 R6: backward branch start, limit completion
        expect_msg("R1/R4/R5/R6 backward-branch full digest", 16'h0100, 4'b1101, 3'd4);
        retire(16'h0100, 1'b1, 1'b1, 16'h00F0, 1'b0, 1'b0, 1'b0);
        retire(16'h0104, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        fwd_br(16'h0108, 1'b1);
        fwd_br(16'h010C, 1'b0);
        retire(16'h0110, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        fwd_br(16'h0114, 1'b1);
        fwd_br(16'h0118, 1'b1);
        quiet(3);
        send_ack();

        // R1 negative (forward branch) then R2 call start, R6 short on trace entry
        expect_msg("R1/R2/R6 call start short digest", 16'h0210, 4'b0010, 3'd2);
        fwd_br(16'h0200, 1'b1);
        call_at(16'h0210);
        fwd_br(16'h0214, 1'b0);
        fwd_br(16'h0218, 1'b1);
        enter_trace(16'h0300);
        quiet(3);
        send_ack();

        // R1 negative in trace, R2 trace-exit start, R3 triggers ignored while building
        expect_msg("R2/R3 trace-exit digest", 16'h0490, 4'b1010, 3'd4);
        retire(16'h0480, 1'b1, 1'b1, 16'h0400, 1'b0, 1'b1, 1'b0);
        retire(16'h0490, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
        fwd_br(16'h0504, 1'b0);
        retire(16'h0508, 1'b1, 1'b1, 16'h0500, 1'b0, 1'b0, 1'b0);
        call_at(16'h050C);
        fwd_br(16'h0510, 1'b0);
        fwd_br(16'h0514, 1'b1);
        quiet(3);
        send_ack();

        // R7: accepted digest, then one completes while ack owed
        expect_msg("R7 first digest before owed ack", 16'h0600, 4'b1111, 3'd4);
        call_at(16'h0600);
        for (int i = 0; i < 4; i++) fwd_br(16'h0604 + 16'(4 * i), 1'b1);
        quiet(3);
        o0 = offers;
        call_at(16'h0700);
        for (int i = 0; i < 4; i++) fwd_br(16'h0704 + 16'(4 * i), 1'b0);
        quiet(3);
        chk("R7 dropped while ack owed", offers == o0, 64'(offers), 64'(o0));
        send_ack();
        // R6 zero-length short digest after ack
        expect_msg("R6/R7 zero-length after ack", 16'h0800, 4'b0000, 3'd0);
        call_at(16'h0800);
        enter_trace(16'h0900);
        quiet(3);
        send_ack();

        // R8: refused offer is dropped, no ack owed afterwards
        msg_ready = 1'b0;
        o0 = offers; a0 = accepts;
        call_at(16'h0A00);
        for (int i = 0; i < 4; i++) fwd_br(16'h0A04 + 16'(4 * i), 1'b1);
        quiet(3);
        chk("R8 offered once", offers == o0 + 1, 64'(offers), 64'(o0 + 1));
        chk("R8 not accepted", accepts == a0, 64'(accepts), 64'(a0));
        msg_ready = 1'b1;
        expect_msg("R8 next digest needs no ack", 16'h0B80, 4'b0000, 3'd4);
        call_at(16'h0B80);
        for (int i = 0; i < 4; i++) fwd_br(16'h0B84 + 16'(4 * i), 1'b0);
        quiet(3);
        send_ack();

        // R9: trace-entry completion on a trace-exit instruction
        expect_msg("R9 completion beats exit trigger", 16'h0B00, 4'b0101, 3'd3);
        call_at(16'h0B00);
        fwd_br(16'h0B04, 1'b1);
        fwd_br(16'h0B08, 1'b0);
        fwd_br(16'h0B0C, 1'b1);
        retire(16'h0B10, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
        quiet(3);
        send_ack();
        o0 = offers;
        for (int i = 0; i < 4; i++) fwd_br(16'h0B20 + 16'(4 * i), 1'b1);
        quiet(3);
        chk("R9 no start from exit", offers == o0, 64'(offers), 64'(o0));

        // R9: limit completion on a backward taken branch
        expect_msg("R9 limit on backward branch", 16'h0C00, 4'b1111, 3'd4);
        call_at(16'h0C00);
        fwd_br(16'h0C04, 1'b1);
        fwd_br(16'h0C08, 1'b1);
        fwd_br(16'h0C0C, 1'b1);
        retire(16'h0C10, 1'b1, 1'b1, 16'h0C00, 1'b0, 1'b0, 1'b0);
        quiet(3);
        send_ack();
        o0 = offers;
        for (int i = 0; i < 4; i++) fwd_br(16'h0C20 + 16'(4 * i), 1'b0);
        quiet(3);
        chk("R9 no start from limit branch", offers == o0, 64'(offers), 64'(o0));

        chk("R6 all expected digests seen", expq.size() == 0, 64'(expq.size()), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule